// File: doc/BRIEF.md
# Ones-Count Filtered Associative Memory

This block is a small associative memory that searches all of its entries in parallel. Each entry stores a data word and a short tag, the number of ones in that word. The tag is computed when the word is written and kept in a tag array beside the data array. Each entry also has an invalid bit.

A search runs in two stages. First, the ones-count of the key is compared against the tag of every entry. Only entries that are valid and whose tag equals the key's tag go on to the full data comparison. The block reports three results: whether any entry matched, the index of the matching entry, and how many entries took part in the full comparison. The count lets an observer see how well the tag stage filtered the search.

Writes and invalidations use a simple address port. Searches are started with a single-cycle strobe. Results are registered and appear one cycle after the strobe.

Top module: `pcam_top`

## Requirements
- R1: After reset every entry is invalid, and `hit`, `hit_idx`, `cmp_cnt` and `res_vld` are all 0.
- R2: A write stores `wr_data` at `wr_addr` and marks that entry valid. A search started in the next cycle or later sees the new contents.
- R3: The stored tag is the ones-count of the word. Its width is ceil(log2(DATA_W+2)) bits, so a 14-bit word of all ones gets tag 14.
- R4: `res_vld` is 1 in exactly the cycle after a cycle with `srch_start` high. In every other cycle `hit`, `hit_idx` and `cmp_cnt` keep their previous values.
- R5: When exactly one valid entry holds the key, `hit` is 1 and `hit_idx` is that entry's index.
- R6: When several valid entries hold the key, `hit_idx` is the lowest of their indices.
- R7: When no valid entry holds the key, `hit` is 0 and `hit_idx` is 0.
- R8: An invalid entry never matches, whatever it stores. `inv_en` marks the entry at `inv_addr` invalid. If a write and an invalidation hit the same address in the same cycle, the entry ends up invalid.
- R9: `cmp_cnt` equals the number of valid entries whose tag equals the ones-count of the key.
- R10: A search started in the same cycle as a write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | IDX_W | Entry to write |
| wr_data | input | DATA_W | Word to store |
| inv_en | input | 1 | Invalidate strobe |
| inv_addr | input | IDX_W | Entry to invalidate |
| srch_start | input | 1 | Search strobe |
| srch_key | input | DATA_W | Search key |
| res_vld | output | 1 | Search result present this cycle |
| hit | output | 1 | A valid entry matched |
| hit_idx | output | IDX_W | Lowest matching index, 0 on a miss |
| cmp_cnt | output | CNT_W | Entries that took part in the full comparison |

## Verification
All three search results appear together, one clock edge after the edge that samples `srch_start`. The bench drives inputs on the falling edge and pushes the expected result into a queue at that moment. A monitor pops the queue on the next falling edge where `res_vld` is high. A result with no expected item, or an expected item left in the queue at the end, counts as a failure.

Contents changed by a write or an invalidation are visible only from the edge after the command. The reference model therefore computes a search's expectation before it applies any command issued in the same cycle.

The hold behaviour is checked by sampling the outputs over several idle cycles after a result.

// File: rtl/pcam_pkg.sv
package pcam_pkg;

   // Implementation choices for the ones-count extractor
   localparam int CNT_STYLE_LOOP  = 0;
   localparam int CNT_STYLE_CHUNK = 1;

   // Width of the partial counters used by the chunked extractor
   localparam int CHUNK_BITS = 4;
   localparam int CHUNK_CNT_W = $clog2(CHUNK_BITS + 1);

endpackage

// File: rtl/pcam_param_extract.sv
module pcam_param_extract #(
   parameter int DATA_W    = 14,
   parameter int PAR_W     = $clog2(DATA_W + 2),
   parameter int CNT_STYLE = pcam_pkg::CNT_STYLE_CHUNK
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [PAR_W-1:0]  par_o
);
   import pcam_pkg::*;

   initial begin
      if (PAR_W < $clog2(DATA_W + 1)) $error("pcam_param_extract: PAR_W too narrow");
   end

   generate
      if (CNT_STYLE == CNT_STYLE_LOOP) begin : g_loop
         always_comb begin
            par_o = '0;
            for (int i = 0; i < DATA_W; i++) begin
               par_o = par_o + PAR_W'(data_i[i]);
            end
         end
      end else begin : g_chunk
         localparam int NCH = (DATA_W + CHUNK_BITS - 1) / CHUNK_BITS;
         logic [NCH*CHUNK_BITS-1:0] padded;
         logic [CHUNK_CNT_W-1:0]    part [NCH];

         always_comb begin
            padded = '0;
            padded[DATA_W-1:0] = data_i;
         end

         for (genvar c = 0; c < NCH; c++) begin : g_part
            always_comb begin
               part[c] = '0;
               for (int b = 0; b < CHUNK_BITS; b++) begin
                  part[c] = part[c] + CHUNK_CNT_W'(padded[c*CHUNK_BITS + b]);
               end
            end
         end

         always_comb begin
            par_o = '0;
            for (int c = 0; c < NCH; c++) begin
               par_o = par_o + PAR_W'(part[c]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pcam_entry.sv
module pcam_entry #(
   parameter int DATA_W = 14,
   parameter int PAR_W  = $clog2(DATA_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              inv_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [PAR_W-1:0]  wpar_i,
   input  logic [DATA_W-1:0] key_i,
   input  logic [PAR_W-1:0]  kpar_i,
   output logic              pass_o,
   output logic              hit_o
);
   logic [DATA_W-1:0] data_q;
   logic [PAR_W-1:0]  par_q;
   logic              inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         par_q  <= '0;
      end else if (wr_i) begin
         data_q <= wdata_i;
         par_q  <= wpar_i;
      end
   end

   // Invalidation has priority over a write to the same entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      inv_q <= 1'b1;
      else if (inv_i)  inv_q <= 1'b1;
      else if (wr_i)   inv_q <= 1'b0;
   end

   // Stage one: tag filter. Stage two: word compare, enabled by stage one
   always_comb begin
      pass_o = !inv_q && (par_q == kpar_i);
      hit_o  = 1'b0;
      if (pass_o) hit_o = (data_q == key_i);
   end

endmodule

// File: rtl/pcam_resolve.sv
module pcam_resolve #(
   parameter int DEPTH = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0] hit_vec_i,
   input  logic [DEPTH-1:0] pass_vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [CNT_W-1:0] cnt_o
);
   // Lowest index wins: scan downwards so the last assignment is the lowest
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit_vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         cnt_o = cnt_o + CNT_W'(pass_vec_i[i]);
      end
   end

endmodule

// File: rtl/pcam_top.sv
module pcam_top #(
   parameter int DATA_W    = 14,
   parameter int DEPTH     = 16,
   parameter int CNT_STYLE = pcam_pkg::CNT_STYLE_CHUNK,
   localparam int PAR_W    = $clog2(DATA_W + 2),
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              inv_en,
   input  logic [IDX_W-1:0]  inv_addr,
   input  logic              srch_start,
   input  logic [DATA_W-1:0] srch_key,
   output logic              res_vld,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [CNT_W-1:0]  cmp_cnt
);
   initial begin
      if (DATA_W < 1) $error("pcam_top: DATA_W must be positive");
      if (DEPTH < 2)  $error("pcam_top: DEPTH must be at least 2");
      if (CNT_STYLE != pcam_pkg::CNT_STYLE_LOOP && CNT_STYLE != pcam_pkg::CNT_STYLE_CHUNK)
         $error("pcam_top: unknown CNT_STYLE");
   end

   logic [PAR_W-1:0] wpar;
   logic [PAR_W-1:0] kpar;
   logic [DEPTH-1:0] pass_vec;
   logic [DEPTH-1:0] hit_vec;
   logic             any_c;
   logic [IDX_W-1:0] idx_c;
   logic [CNT_W-1:0] cnt_c;

   pcam_param_extract #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CNT_STYLE(CNT_STYLE)) u_wr_extract (
      .data_i (wr_data),
      .par_o  (wpar)
   );

   pcam_param_extract #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CNT_STYLE(CNT_STYLE)) u_key_extract (
      .data_i (srch_key),
      .par_o  (kpar)
   );

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic wsel;
         logic isel;
         assign wsel = wr_en  && (wr_addr  == IDX_W'(e));
         assign isel = inv_en && (inv_addr == IDX_W'(e));

         pcam_entry #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wsel),
            .inv_i   (isel),
            .wdata_i (wr_data),
            .wpar_i  (wpar),
            .key_i   (srch_key),
            .kpar_i  (kpar),
            .pass_o  (pass_vec[e]),
            .hit_o   (hit_vec[e])
         );
      end
   endgenerate

   pcam_resolve #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_resolve (
      .hit_vec_i  (hit_vec),
      .pass_vec_i (pass_vec),
      .any_o      (any_c),
      .idx_o      (idx_c),
      .cnt_o      (cnt_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_vld <= 1'b0;
      else        res_vld <= srch_start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_idx <= '0;
         cmp_cnt <= '0;
      end else if (srch_start) begin
         hit     <= any_c;
         hit_idx <= idx_c;
         cmp_cnt <= cnt_c;
      end
   end

endmodule

// File: rtl/pcam_chk.sv
module pcam_chk #(
   parameter int DEPTH = 16,
   parameter int IDX_W = $clog2(DEPTH),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srch_start,
   input logic             res_vld,
   input logic             hit,
   input logic [IDX_W-1:0] hit_idx,
   input logic [CNT_W-1:0] cmp_cnt
);
   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      srch_start |=> res_vld); // R4

   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_start |=> !res_vld); // R4

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_start |=> ($stable(hit) && $stable(hit_idx) && $stable(cmp_cnt))); // R4

   AST_HIT_NEEDS_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && hit) |-> (cmp_cnt != '0)); // R9

   AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !hit) |-> (hit_idx == '0)); // R7

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_cnt <= CNT_W'(DEPTH)); // R9

endmodule

bind pcam_top pcam_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pcam_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .srch_start (srch_start),
   .res_vld    (res_vld),
   .hit        (hit),
   .hit_idx    (hit_idx),
   .cmp_cnt    (cmp_cnt)
);

// File: tb/pcam_top_tb_top.sv
`timescale 1ns/1ps
module pcam_top_tb_top;
   localparam int DW  = 14;
   localparam int DEP = 16;
   localparam int IW  = 4;
   localparam int CW  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          inv_en = 1'b0;
   logic [IW-1:0] inv_addr = '0;
   logic          srch_start = 1'b0;
   logic [DW-1:0] srch_key = '0;
   logic          res_vld;
   logic          hit;
   logic [IW-1:0] hit_idx;
   logic [CW-1:0] cmp_cnt;

   always #4 clk = ~clk;

   pcam_top #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inv_en(inv_en), .inv_addr(inv_addr),
      .srch_start(srch_start), .srch_key(srch_key),
      .res_vld(res_vld), .hit(hit), .hit_idx(hit_idx), .cmp_cnt(cmp_cnt)
   );

   typedef struct packed {
      logic          hit;
      logic [IW-1:0] idx;
      logic [CW-1:0] cnt;
   } exp_t;

   exp_t          expq [$];
   string         tagq [$];
   logic [DW-1:0] mdata  [DEP];
   logic          mvalid [DEP];
   int            checks = 0;
   int            fails = 0;
   exp_t          cur;
   string         curtag;

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Reference: linear scan over the model contents
   function automatic exp_t model(logic [DW-1:0] key);
      exp_t r;
      r = '0;
      for (int i = DEP - 1; i >= 0; i--) begin
         if (mvalid[i] && mdata[i] == key) begin
            r.hit = 1'b1;
            r.idx = IW'(i);
         end
      end
      for (int i = 0; i < DEP; i++) begin
         if (mvalid[i] && $countones(mdata[i]) == $countones(key)) r.cnt = r.cnt + 1'b1;
      end
      return r;
   endfunction

   task automatic drive(bit we, int wa, logic [DW-1:0] wd, bit ie, int ia,
                        bit se, logic [DW-1:0] key, string tag);
      wr_en = we; wr_addr = IW'(wa); wr_data = wd;
      inv_en = ie; inv_addr = IW'(ia);
      srch_start = se; srch_key = key;
      if (se) begin
         expq.push_back(model(key));  // R10: expectation uses contents before this cycle's commands
         tagq.push_back(tag);
      end
      if (we) begin mdata[wa] = wd; mvalid[wa] = 1'b1; end
      if (ie) mvalid[ia] = 1'b0;      // R8: invalidate wins
      @(negedge clk);
   endtask

   task automatic idle(int n);
      wr_en = 1'b0; inv_en = 1'b0; srch_start = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [DW-1:0] d);
      drive(1'b1, a, d, 1'b0, 0, 1'b0, '0, "R2");
   endtask

   task automatic srch(logic [DW-1:0] k, string tag);
      drive(1'b0, 0, '0, 1'b0, 0, 1'b1, k, tag);
   endtask

   // Monitor: pops one expectation per result
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R4", "result without search", 1, 0);
         end else begin
            cur = expq.pop_front();
            curtag = tagq.pop_front();
            chk(hit == cur.hit, curtag, "hit", int'(hit), int'(cur.hit));
            chk(hit_idx == cur.idx, curtag, "hit_idx", int'(hit_idx), int'(cur.idx));
            chk(cmp_cnt == cur.cnt, curtag, "cmp_cnt", int'(cmp_cnt), int'(cur.cnt));
         end
      end
   end

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic          h0;
      logic [IW-1:0] i0;
      logic [CW-1:0] c0;
      for (int i = 0; i < DEP; i++) begin mdata[i] = '0; mvalid[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(res_vld == 1'b0 && hit == 1'b0, "R1", "res_vld/hit at reset", int'({res_vld, hit}), 0);
      chk(hit_idx == '0 && cmp_cnt == '0, "R1", "idx/cnt at reset", int'({hit_idx, cmp_cnt}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      srch('0, "R1");                 // all entries invalid: miss, count 0
      idle(2);

      wr(3, 14'h00FF);
      wr(5, 14'h0F0F);
      wr(7, 14'h3FFF);
      srch(14'h3FFF, "R3");           // written previous cycle, tag 14
      wr(0, 14'h0000);
      srch(14'h00FF, "R9");           // entries 3 and 5 both have 8 ones
      srch(14'h0000, "R5");
      srch(14'h1234, "R7");           // 5 ones, nothing stored with that count
      srch(14'h0F0F, "R5");
      idle(2);

      // R4: outputs hold while idle
      h0 = hit; i0 = hit_idx; c0 = cmp_cnt;
      idle(3);
      chk(hit == h0 && hit_idx == i0 && cmp_cnt == c0, "R4", "held result",
          int'({hit, hit_idx, cmp_cnt}), int'({h0, i0, c0}));
      chk(res_vld == 1'b0, "R4", "res_vld while idle", int'(res_vld), 0);

      wr(9, 14'h00FF);
      srch(14'h00FF, "R6");           // entries 3 and 9 both match, 3 wins
      drive(1'b0, 0, '0, 1'b1, 3, 1'b0, '0, "R8");
      srch(14'h00FF, "R8");           // entry 3 invalid: 9 wins, count 2
      drive(1'b1, 5, 14'h2AAA, 1'b1, 5, 1'b0, '0, "R8");
      srch(14'h2AAA, "R8");           // write and invalidate collide: stays invalid
      drive(1'b1, 12, 14'h1555, 1'b0, 0, 1'b1, 14'h1555, "R10");
      srch(14'h1555, "R2");
      idle(2);

      // Mixed traffic with a small value pool to force collisions
      for (int n = 0; n < 400; n++) begin
         logic [DW-1:0] pool [6];
         logic [DW-1:0] v;
         logic [DW-1:0] k;
         pool[0] = 14'h00FF; pool[1] = 14'h0F0F; pool[2] = 14'h3FFF;
         pool[3] = 14'h0000; pool[4] = 14'h1555; pool[5] = 14'h2AAA;
         v = ($urandom % 4 == 0) ? DW'($urandom) : pool[$urandom % 6];
         k = ($urandom % 5 == 0) ? DW'($urandom) : pool[$urandom % 6];
         drive(($urandom % 3) == 0, int'($urandom % DEP), v,
               ($urandom % 7) == 0, int'($urandom % DEP),
               ($urandom % 4) != 0, k, "R5");
      end
      idle(3);
      chk(expq.size() == 0, "R4", "missing results", expq.size(), 0);
      finish_run();
   end

endmodule